// File: doc/BRIEF.md
# MII Receive Nibble Deframer

This block sits directly behind the receive half of a media-independent interface. On each rising edge of the receive clock it samples the data-valid strobe, the error strobe and the four data lines. It discards the leading alternating pattern and the start-of-frame delimiter. It then pairs the data nibbles into bytes and streams the bytes out with valid, first and last markers. Only a one-byte holding register lies between the line and the byte output. The holding register is what lets the final byte carry its last marker and the frame's status.

A frame may open with any number of preamble nibbles, down to a single one. The shortest accepted lead-in is one 0x5 nibble followed by one 0xD nibble. When the frame ends, four independent status bits are reported with the last byte:

- a frame-check mismatch;
- a line error seen during the frame;
- a stray trailing nibble;
- a byte count outside the legal window.

The state machine has five states:

- **IDLE**: waiting for the data-valid strobe.
- **PREAMBLE**: skipping 0x5 nibbles.
- **DATA_LO**: expecting the low nibble of a byte.
- **DATA_HI**: expecting the high nibble of a byte.
- **DISCARD**: a malformed lead-in was seen; wait for the strobe to drop.

Transitions:

- **IDLE→PREAMBLE**: strobe high with nibble 0x5.
- **IDLE→DISCARD**: strobe high with any other nibble.
- **PREAMBLE→PREAMBLE**: another 0x5.
- **PREAMBLE→DATA_LO**: delimiter nibble 0xD.
- **PREAMBLE→DISCARD**: any other nibble.
- **PREAMBLE→IDLE**: strobe drops.
- **DATA_LO→DATA_HI**: low nibble taken.
- **DATA_HI→DATA_LO**: byte complete.
- **DATA_LO/DATA_HI→IDLE**: strobe drops; the frame ends.
- **DISCARD→IDLE**: strobe drops.

Top module: `mii_rx_deframer`

## Requirements
- R1: After reset, and whenever no frame is in its data phase, `byte_valid`, `byte_first`, `byte_last` and all status outputs are 0.
- R2: A frame opens with one or more 0x5 nibbles followed by a 0xD nibble. The nibble after the 0xD is the first data nibble. A lead-in of exactly 0x5, 0xD is accepted.
- R3: If the first nibble of a frame is not 0x5, or a nibble other than 0x5 or 0xD follows a 0x5 before the delimiter, the frame produces no output until `mii_dv` has been low.
- R4: Each byte is formed from two nibbles, with `mii_rxd[0]` as the least significant bit of each nibble. The first nibble received supplies bits 3:0 and the second supplies bits 7:4.
- R5: `byte_valid` pulses once per forwarded byte, in arrival order. `byte_first` is set on the first forwarded byte only, and `byte_last` on the final forwarded byte only.
- R6: `st_crc_bad` is 1 on the last byte unless the reflected CRC-32 register meets the residue. The register uses polynomial 0xEDB88320, starts at all ones, and runs over every whole data byte including the FCS. The residue is the bit reversal of 0xC704DD7B.
- R7: `st_rx_err` is 1 on the last byte if `mii_er` was sampled high while `mii_dv` was high at any point during the frame.
- R8: If `mii_dv` drops after an odd number of data nibbles, the incomplete nibble is dropped and `st_dribble` is 1 on the last byte. Otherwise `st_dribble` is 0.
- R9: `st_len_err` is 1 on the last byte when the count of whole data bytes is below `MIN_BYTES` or above `MAX_BYTES`. Only the first `MAX_BYTES` bytes are forwarded.
- R10: The four status outputs are 0 in every cycle in which `byte_last` is 0.
- R11: A frame that ends before one whole data byte produces no output at all.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock from the PHY; all sampling on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| mii_dv | input | 1 | Receive data valid |
| mii_er | input | 1 | Receive error strobe |
| mii_rxd | input | 4 | Receive nibble, bit 0 least significant |
| byte_valid | output | 1 | One-cycle pulse marking a forwarded byte |
| byte_data | output | 8 | Forwarded byte |
| byte_first | output | 1 | Marks the first byte of a frame |
| byte_last | output | 1 | Marks the last byte of a frame; status is valid |
| st_crc_bad | output | 1 | Frame check failed |
| st_rx_err | output | 1 | Line error seen during the frame |
| st_dribble | output | 1 | Odd trailing nibble was dropped |
| st_len_err | output | 1 | Byte count outside the legal window |

## Verification
Every cycle, the assertions check the following:

- No byte leaves the block while it is idle or discarding.
- The delimiter was really the nibble seen on entry to the data phase.
- The first and last markers and the status bits never appear without a valid byte.
- The byte counter stays within its saturation bound.

Whether the bytes carry the right values in the right order, and whether each status bit is correct, can only be shown by the bench. It drives frames with every preamble length in a range, byte counts on both sides of each length limit, odd trailing nibbles, corrupted check sequences, line errors and malformed lead-ins, and compares the results with values it computes itself.

// File: rtl/mii_rx_pkg.sv
package mii_rx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREAMBLE,
        ST_DATA_LO,
        ST_DATA_HI,
        ST_DISCARD
    } rx_state_e;

    typedef struct packed {
        logic crc_bad;
        logic rx_err;
        logic dribble;
        logic len_err;
    } rx_status_t;

    localparam logic [3:0]  NIB_PRE         = 4'h5;
    localparam logic [3:0]  NIB_SFD         = 4'hD;
    localparam logic [31:0] CRC_POLY_REFL   = 32'hEDB88320;
    localparam logic [31:0] CRC_INIT        = 32'hFFFFFFFF;
    localparam logic [31:0] CRC_RESIDUE_MSB = 32'hC704DD7B;

    function automatic logic [31:0] bit_rev32(input logic [31:0] v);
        logic [31:0] r;
        for (int i = 0; i < 32; i++) r[i] = v[31-i];
        return r;
    endfunction

    // one byte through the reflected CRC-32 register, LSB first
    function automatic logic [31:0] crc_byte(input logic [31:0] c, input logic [7:0] b);
        logic [31:0] r;
        r = c ^ {24'h0, b};
        for (int i = 0; i < 8; i++) r = r[0] ? ((r >> 1) ^ CRC_POLY_REFL) : (r >> 1);
        return r;
    endfunction

endpackage

// File: rtl/mii_rx_crc.sv
module mii_rx_crc
    import mii_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       en,
    input  logic [7:0] data,
    output logic       crc_ok
);
    localparam logic [31:0] RESIDUE_REFL = bit_rev32(CRC_RESIDUE_MSB);

    logic [31:0] crc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      crc_q <= CRC_INIT;
        else if (clear)  crc_q <= CRC_INIT;
        else if (en)     crc_q <= crc_byte(crc_q, data);
    end

    assign crc_ok = (crc_q == RESIDUE_REFL);

    assert_no_clear_and_update_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(clear && en));
endmodule

// File: rtl/mii_rx_lencnt.sv
module mii_rx_lencnt #(
    parameter int MIN_BYTES = 64,
    parameter int MAX_BYTES = 1518
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic inc,
    output logic at_cap,
    output logic len_bad
);
    localparam int CW = $clog2(MAX_BYTES + 2);
    localparam logic [CW-1:0] CAP  = CW'(MAX_BYTES);
    localparam logic [CW-1:0] SAT  = CW'(MAX_BYTES + 1);
    localparam logic [CW-1:0] LOW  = CW'(MIN_BYTES);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      cnt_q <= '0;
        else if (clear)                  cnt_q <= '0;
        else if (inc && cnt_q != SAT)    cnt_q <= cnt_q + 1'b1;
    end

    assign at_cap  = (cnt_q >= CAP);
    assign len_bad = (cnt_q < LOW) || (cnt_q > CAP);

    assert_cnt_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= SAT);
endmodule

// File: rtl/mii_rx_outstage.sv
module mii_rx_outstage
    import mii_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [7:0] load_byte,
    input  logic       flush,
    input  rx_status_t flush_status,
    output logic       o_valid,
    output logic [7:0] o_data,
    output logic       o_first,
    output logic       o_last,
    output rx_status_t o_status
);
    logic       hold_full_q;
    logic       hold_first_q;
    logic [7:0] hold_data_q;
    logic       seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_full_q  <= 1'b0;
            hold_first_q <= 1'b0;
            hold_data_q  <= '0;
            seen_q       <= 1'b0;
            o_valid      <= 1'b0;
            o_data       <= '0;
            o_first      <= 1'b0;
            o_last       <= 1'b0;
            o_status     <= '0;
        end else begin
            o_valid  <= 1'b0;
            o_first  <= 1'b0;
            o_last   <= 1'b0;
            o_status <= '0;
            if (load) begin
                if (hold_full_q) begin
                    o_valid <= 1'b1;
                    o_data  <= hold_data_q;
                    o_first <= hold_first_q;
                end
                hold_data_q  <= load_byte;
                hold_first_q <= !seen_q;
                hold_full_q  <= 1'b1;
                seen_q       <= 1'b1;
            end else if (flush) begin
                if (hold_full_q) begin
                    o_valid  <= 1'b1;
                    o_data   <= hold_data_q;
                    o_first  <= hold_first_q;
                    o_last   <= 1'b1;
                    o_status <= flush_status;
                end
                hold_full_q <= 1'b0;
                seen_q      <= 1'b0;
            end
        end
    end

    assert_last_needs_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
        o_last |-> o_valid);
    assert_first_needs_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
        o_first |-> o_valid);
    assert_status_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !o_last |-> (o_status == '0));
    assert_no_load_flush_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(load && flush));
endmodule

// File: rtl/mii_rx_deframer.sv
module mii_rx_deframer
    import mii_rx_pkg::*;
#(
    parameter int MIN_BYTES = 64,
    parameter int MAX_BYTES = 1518
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mii_dv,
    input  logic       mii_er,
    input  logic [3:0] mii_rxd,
    output logic       byte_valid,
    output logic [7:0] byte_data,
    output logic       byte_first,
    output logic       byte_last,
    output logic       st_crc_bad,
    output logic       st_rx_err,
    output logic       st_dribble,
    output logic       st_len_err
);
    rx_state_e  state_q, state_d;
    logic [3:0] lo_q;
    logic       err_q;

    logic       frame_start, sfd_hit, byte_done, load, flush, dribble;
    logic [7:0] new_byte;
    logic       crc_ok, at_cap, len_bad;
    rx_status_t status, o_status;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (mii_dv) state_d = (mii_rxd == NIB_PRE) ? ST_PREAMBLE : ST_DISCARD;
            end
            ST_PREAMBLE: begin
                if (!mii_dv)                  state_d = ST_IDLE;
                else if (mii_rxd == NIB_SFD)  state_d = ST_DATA_LO;
                else if (mii_rxd != NIB_PRE)  state_d = ST_DISCARD;
            end
            ST_DATA_LO: state_d = mii_dv ? ST_DATA_HI : ST_IDLE;
            ST_DATA_HI: state_d = mii_dv ? ST_DATA_LO : ST_IDLE;
            ST_DISCARD: if (!mii_dv) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // control outputs of the state machine
    always_comb begin
        frame_start = (state_q == ST_IDLE) && mii_dv;
        sfd_hit     = (state_q == ST_PREAMBLE) && mii_dv && (mii_rxd == NIB_SFD);
        byte_done   = (state_q == ST_DATA_HI) && mii_dv;
        new_byte    = {mii_rxd, lo_q};
        load        = byte_done && !at_cap;
        flush       = ((state_q == ST_DATA_LO) || (state_q == ST_DATA_HI)) && !mii_dv;
        dribble     = (state_q == ST_DATA_HI);
        status.crc_bad = !crc_ok;
        status.rx_err  = err_q;
        status.dribble = dribble;
        status.len_err = len_bad;
    end

    // nibble holding and sticky line-error flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q  <= '0;
            err_q <= 1'b0;
        end else begin
            if ((state_q == ST_DATA_LO) && mii_dv) lo_q <= mii_rxd;
            if (frame_start)        err_q <= mii_er;
            else if (mii_dv && mii_er) err_q <= 1'b1;
        end
    end

    mii_rx_crc u_crc (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (sfd_hit),
        .en     (byte_done),
        .data   (new_byte),
        .crc_ok (crc_ok)
    );

    mii_rx_lencnt #(
        .MIN_BYTES (MIN_BYTES),
        .MAX_BYTES (MAX_BYTES)
    ) u_len (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (sfd_hit),
        .inc     (byte_done),
        .at_cap  (at_cap),
        .len_bad (len_bad)
    );

    mii_rx_outstage u_out (
        .clk          (clk),
        .rst_n        (rst_n),
        .load         (load),
        .load_byte    (new_byte),
        .flush        (flush),
        .flush_status (status),
        .o_valid      (byte_valid),
        .o_data       (byte_data),
        .o_first      (byte_first),
        .o_last       (byte_last),
        .o_status     (o_status)
    );

    assign st_crc_bad = o_status.crc_bad;
    assign st_rx_err  = o_status.rx_err;
    assign st_dribble = o_status.dribble;
    assign st_len_err = o_status.len_err;

    assert_idle_silent_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |=> !byte_valid);
    assert_discard_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DISCARD) |=> !byte_valid);
    assert_sfd_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PREAMBLE && mii_dv && mii_rxd == NIB_SFD) |=> (state_q == ST_DATA_LO));
    assert_discard_exit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DISCARD && mii_dv) |=> (state_q == ST_DISCARD));
endmodule

// File: tb/sim_mii_rx_deframer.sv
module sim_mii_rx_deframer;
    localparam int CLK_PERIOD = 10;
    localparam int MINB = 8;
    localparam int MAXB = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mii_dv = 1'b0, mii_er = 1'b0;
    logic [3:0] mii_rxd = 4'h0;
    logic byte_valid, byte_first, byte_last;
    logic [7:0] byte_data;
    logic st_crc_bad, st_rx_err, st_dribble, st_len_err;

    int checks = 0, errors = 0, cyc = 0;
    bit done = 0;

    logic [7:0] tx [0:63];
    logic [7:0] got [0:63];
    int got_n, first_cnt, first_idx, last_cnt, last_idx, stray;
    logic [3:0] st_got;

    mii_rx_deframer #(.MIN_BYTES(MINB), .MAX_BYTES(MAXB)) u0 (
        .clk(clk), .rst_n(rst_n), .mii_dv(mii_dv), .mii_er(mii_er), .mii_rxd(mii_rxd),
        .byte_valid(byte_valid), .byte_data(byte_data), .byte_first(byte_first),
        .byte_last(byte_last), .st_crc_bad(st_crc_bad), .st_rx_err(st_rx_err),
        .st_dribble(st_dribble), .st_len_err(st_len_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // output monitor, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (!byte_last && (st_crc_bad | st_rx_err | st_dribble | st_len_err)) stray++;
            if (byte_valid) begin
                if (got_n < 64) got[got_n] = byte_data;
                if (byte_first) begin first_cnt++; first_idx = got_n; end
                if (byte_last) begin
                    last_cnt++; last_idx = got_n;
                    st_got = {st_crc_bad, st_rx_err, st_dribble, st_len_err};
                end
                got_n++;
            end else if (byte_first || byte_last) stray++;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] b);
        logic [31:0] r;
        r = c ^ {24'h0, b};
        for (int k = 0; k < 8; k++) r = r[0] ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
        return r;
    endfunction

    task automatic nib(input logic [3:0] v, input logic er);
        @(negedge clk);
        mii_dv = 1'b1; mii_rxd = v; mii_er = er;
    endtask

    task automatic gap(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            mii_dv = 1'b0; mii_rxd = 4'h0; mii_er = 1'b0;
        end
    endtask

    // bad_pos < 0: well-formed lead-in; otherwise bad_pos 0x5 nibbles, then bad_v
    task automatic run_frame(input string tag, input int pre_n, input int nb, input bit corrupt,
                             input int er_at, input bit drib, input int bad_pos, input logic [3:0] bad_v);
        logic [31:0] c;
        int fwd, mism;
        bit exp_crc_bad, exp_len, exp_err;
        for (int i = 0; i < nb; i++) tx[i] = 8'((i * 37 + pre_n * 11 + nb) & 255);
        if (nb >= 4) begin
            c = 32'hFFFFFFFF;
            for (int i = 0; i < nb - 4; i++) c = crc_step(c, tx[i]);
            c = ~c;
            for (int k = 0; k < 4; k++) tx[nb-4+k] = c[8*k +: 8];
        end
        if (corrupt && nb > 0) tx[0] = tx[0] ^ 8'h01;
        c = 32'hFFFFFFFF;
        for (int i = 0; i < nb; i++) c = crc_step(c, tx[i]);
        exp_crc_bad = (c != 32'hDEBB20E3);
        exp_len = (nb < MINB) || (nb > MAXB);
        exp_err = (er_at >= 0) && (er_at < 2 * nb);
        got_n = 0; first_cnt = 0; last_cnt = 0; first_idx = -1; last_idx = -1; stray = 0; st_got = 4'h0;

        if (bad_pos >= 0) begin
            for (int p = 0; p < bad_pos; p++) nib(4'h5, 1'b0);
            nib(bad_v, 1'b0);
        end
        for (int p = 0; p < pre_n; p++) nib(4'h5, 1'b0);
        nib(4'hD, 1'b0);
        for (int i = 0; i < nb; i++) begin
            nib(tx[i][3:0], (er_at == 2 * i) ? 1'b1 : 1'b0);
            nib(tx[i][7:4], (er_at == 2 * i + 1) ? 1'b1 : 1'b0);
        end
        if (drib) nib(4'hA, 1'b0);
        gap(4);

        fwd = (bad_pos >= 0) ? 0 : ((nb > MAXB) ? MAXB : nb);
        chk(got_n == fwd, {tag, " byte count R5 R9"}, got_n, fwd);
        chk(stray == 0, {tag, " markers/status outside last R10"}, stray, 0);
        if (fwd > 0) begin
            mism = 0;
            for (int i = 0; i < fwd && i < got_n; i++) if (got[i] !== tx[i]) mism++;
            chk(mism == 0, {tag, " byte values nibble order R4"}, mism, 0);
            chk(first_cnt == 1 && first_idx == 0, {tag, " first flag R5"}, first_idx, 0);
            chk(last_cnt == 1 && last_idx == fwd - 1, {tag, " last flag R5"}, last_idx, fwd - 1);
            chk(st_got[3] == exp_crc_bad, {tag, " crc status R6"}, st_got[3], exp_crc_bad);
            chk(st_got[2] == exp_err, {tag, " rx error status R7"}, st_got[2], exp_err);
            chk(st_got[1] == drib, {tag, " dribble status R8"}, st_got[1], drib);
            chk(st_got[0] == exp_len, {tag, " length status R9"}, st_got[0], exp_len);
        end else begin
            chk(last_cnt == 0 && first_cnt == 0, {tag, " silent frame R3 R11"}, last_cnt, 0);
        end
    endtask

    initial begin
        int sizes [11] = '{0, 1, 3, 4, 7, 8, 9, 13, 20, 21, 25};
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(byte_valid == 0 && byte_first == 0 && byte_last == 0, "reset outputs R1", byte_valid, 0);
        chk({st_crc_bad, st_rx_err, st_dribble, st_len_err} == 4'h0, "reset status R1", 0, 0);
        rst_n = 1'b1;
        gap(3);
        chk(byte_valid == 0, "idle after reset R1", byte_valid, 0);

        // R2 R4 R5 R6 R8 R9 R11: preamble length x size x dribble sweep
        for (int p = 1; p <= 7; p++)
            for (int s = 0; s < 11; s++)
                for (int d = 0; d < 2; d++)
                    run_frame("sweep R2", p, sizes[s], 1'b0, -1, d[0], -1, 4'h0);

        // R6: corrupted check sequence
        for (int n = 8; n <= 20; n += 4) run_frame("corrupt R6", 3, n, 1'b1, -1, 1'b0, -1, 4'h0);

        // R7: line error on each data nibble
        for (int e = 0; e < 20; e++) run_frame("rxerr R7", 2, 10, 1'b0, e, 1'b0, -1, 4'h0);

        // R3: malformed lead-in sweep
        for (int bp = 0; bp < 4; bp++)
            for (int v = 0; v < 16; v++)
                if (v != 5 && !(v == 13 && bp > 0))
                    run_frame("badlead R3", 2, 10, 1'b0, -1, 1'b0, bp, 4'(v));

        // R2: a clean frame right after the discarded ones still works
        run_frame("recover R2", 1, 12, 1'b0, -1, 1'b0, -1, 4'h0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule